// File: doc/BRIEF.md
# Switch-Selected Digit Serial Sender

This block turns a small binary value set on slide switches into a printable decimal character and sends it over an asynchronous serial transmit line when a push-button is pressed. The same value is shown all the time as a decimal digit on one seven-segment display position. The segment and position outputs are active-low. The other display positions stay dark.

The button is asynchronous to the core clock. It is first retimed by a two-flop synchroniser. A small state machine then turns each rising edge of the retimed level into a trigger exactly one clock cycle long. A trigger that arrives while the line is idle captures the character and starts one 8N1 frame. A trigger that arrives during a frame is dropped.

The block has no stream handshake. The switches are plain levels. The only form of back-pressure is the `busy` output: while it is high, a press is discarded and is not queued. The bit period is the clock frequency divided by the baud rate, rounded to the nearest integer. With the default 100 MHz clock and 9600 baud this gives 10417 cycles.

Top module: `sw_char_sender`

## Requirements
- R1: While `rst_n` is low, `tx` is 1, `busy` is 0 and `seg_n` is all ones (blank).
- R2: A frame is a start bit (0), then eight data bits sent least significant bit first, then a stop bit (1). Each bit is held for exactly DIV = round(CLK_HZ/BAUD) clock cycles.
- R3: The character sent is 0x30 plus the switch value, captured in the clock cycle of the trigger. Switch changes after that point do not alter the frame in progress.
- R4: `seg_n` shows the switch value as a decimal digit one clock after the switches change. Bit 0 is segment a and bit 6 is segment g, and 0 means lit. Active-low codes for 0 to 7: 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78.
- R5: `an_n` has only bit DIGIT_SEL low (default bit 0). All other bits are high.
- R6: A button level that is stable before a rising clock edge pulls `tx` low on the fourth rising edge after it. This covers two synchroniser stages, one edge-detector state and one transmitter state.
- R7: A press produces exactly one frame, however long the button is held. The button must go low and be seen low before another frame can start.
- R8: `busy` is high from the cycle the start bit begins to the last cycle of the stop bit, which is exactly 10*DIV cycles. `tx` is 1 whenever `busy` is 0.
- R9: A press whose trigger falls while `busy` is high is ignored. No frame follows it and the character being sent is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | SW_W (3) | Switch value to display and send |
| btn | input | 1 | Asynchronous push-button, high when pressed |
| tx | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | High while a frame is on the line |
| seg_n | output | 7 | Active-low segments a (bit 0) to g (bit 6) |
| an_n | output | AN_W (4) | Active-low digit position selects |

## Verification
If the bit counter or the baud counter goes wrong, a bit on `tx` lasts the wrong number of cycles. The length of `busy` also departs from 10*DIV. The bench compares the line on every cycle of every frame, so such a fault shows up within one bit period. If the edge detector sticks in its firing or holding state, the result is either a second frame while the button is held or a missing frame on the next press. Both are seen within one frame time, because the line is watched for silence after each frame. A wrong captured character shows in the data bits of that same frame, and a wrong segment code shows one cycle after the switches change.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    EDG_IDLE,
    EDG_FIRE,
    EDG_HOLD
  } edge_state_t;

  typedef enum logic [1:0] {
    TXS_IDLE,
    TXS_START,
    TXS_DATA,
    TXS_STOP
  } tx_state_t;

  // active-high segment pattern, bit0 = a ... bit6 = g
  function automatic logic [6:0] digit_segs(input logic [3:0] d);
    logic [6:0] p;
    case (d)
      4'd0: p = 7'b0111111;
      4'd1: p = 7'b0000110;
      4'd2: p = 7'b1011011;
      4'd3: p = 7'b1001111;
      4'd4: p = 7'b1100110;
      4'd5: p = 7'b1101101;
      4'd6: p = 7'b1111101;
      4'd7: p = 7'b0000111;
      4'd8: p = 7'b1111111;
      4'd9: p = 7'b1101111;
      default: p = 7'b0000000;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/swc_btn_oneshot.sv
module swc_btn_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_async,
  output logic fire
);
  import swc_pkg::*;

  logic [1:0]  sync_q;
  edge_state_t st_q, st_d;

  // two-stage retiming of the raw button
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], btn_async};
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      EDG_IDLE: if (sync_q[1]) st_d = EDG_FIRE;
      EDG_FIRE: st_d = sync_q[1] ? EDG_HOLD : EDG_IDLE;
      EDG_HOLD: if (!sync_q[1]) st_d = EDG_IDLE;
      default:  st_d = EDG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= EDG_IDLE;
    else        st_q <= st_d;
  end

  assign fire = (st_q == EDG_FIRE);

  // R6: a trigger lasts one cycle
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R6: a trigger only follows a retimed high level
  a_r6_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(sync_q[1]));
  // R7: no new trigger until the retimed level has been seen low
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EDG_HOLD && sync_q[1]) |=> !fire);

endmodule

// File: rtl/swc_baud_tick.sv
module swc_baud_tick #(
  parameter int unsigned DIV = 10417
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = !clr && (cnt_q == LAST);

  // R2: count stays within one bit period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R2: a cleared counter restarts a full bit period
  a_r2_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/swc_uart_tx.sv
module swc_uart_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              tick,
  output logic              tx,
  output logic              busy
);
  import swc_pkg::*;

  localparam int unsigned IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_BIT = IW'(DATA_W - 1);

  tx_state_t         st_q;
  logic [DATA_W-1:0] char_q;
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     idx_nx;
  logic              tx_q;

  assign idx_nx = idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TXS_IDLE;
      char_q <= '0;
      idx_q  <= '0;
      tx_q   <= 1'b1;
    end else begin
      case (st_q)
        TXS_IDLE: if (start) begin
          st_q   <= TXS_START;
          char_q <= din;
          tx_q   <= 1'b0;
        end
        TXS_START: if (tick) begin
          st_q  <= TXS_DATA;
          idx_q <= '0;
          tx_q  <= char_q[0];
        end
        TXS_DATA: if (tick) begin
          if (idx_q == LAST_BIT) begin
            st_q <= TXS_STOP;
            tx_q <= 1'b1;
          end else begin
            idx_q <= idx_nx;
            tx_q  <= char_q[idx_nx];
          end
        end
        TXS_STOP: if (tick) st_q <= TXS_IDLE;
        default: st_q <= TXS_IDLE;
      endcase
    end
  end

  assign tx   = tx_q;
  assign busy = (st_q != TXS_IDLE);

  // R8: line is high whenever no frame is running
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  // R2: a frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  // R2: stop bit is high
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TXS_STOP) |-> tx);
  // R9: a trigger during a frame leaves the captured character alone
  a_r9_keep_char: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(char_q));

endmodule

// File: rtl/swc_seg_drv.sv
module swc_seg_drv #(
  parameter int unsigned VAL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] val,
  output logic [6:0]       seg_n
);
  import swc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_n <= 7'h7F;
    else        seg_n <= ~digit_segs(4'(val));
  end

  // R4: the segment code always shows at least one lit segment after reset
  a_r4_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (seg_n != 7'h7F));

endmodule

// File: rtl/sw_char_sender.sv
module sw_char_sender #(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned BAUD      = 9600,
  parameter int unsigned SW_W      = 3,
  parameter int unsigned AN_W      = 4,
  parameter int unsigned DIGIT_SEL = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] sw,
  input  logic            btn,
  output logic            tx,
  output logic            busy,
  output logic [6:0]      seg_n,
  output logic [AN_W-1:0] an_n
);
  localparam int unsigned DIV    = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int unsigned CHAR_W = 8;
  localparam logic [CHAR_W-1:0] ASCII_ZERO = 8'h30;

  logic              fire;
  logic              tick;
  logic [CHAR_W-1:0] char_w;

  assign char_w = ASCII_ZERO + CHAR_W'(sw);

  swc_btn_oneshot u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_async (btn),
    .fire      (fire)
  );

  swc_baud_tick #(.DIV(DIV)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!busy),
    .tick  (tick)
  );

  swc_uart_tx #(.DATA_W(CHAR_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire),
    .din   (char_w),
    .tick  (tick),
    .tx    (tx),
    .busy  (busy)
  );

  swc_seg_drv #(.VAL_W(SW_W)) u_seg (
    .clk   (clk),
    .rst_n (rst_n),
    .val   (sw),
    .seg_n (seg_n)
  );

  for (genvar g = 0; g < AN_W; g++) begin : g_anode
    assign an_n[g] = (g != DIGIT_SEL);
  end

endmodule

// File: tb/sw_char_sender_test.sv
module sw_char_sender_test;

  localparam int unsigned CLK_HZ = 96;
  localparam int unsigned BAUD   = 8;
  localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;  // 12

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sw = 3'd0;
  logic       btn = 1'b0;
  logic       tx, busy;
  logic [6:0] seg_n;
  logic [3:0] an_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sw_char_sender #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst_n(rst_n), .sw(sw), .btn(btn),
    .tx(tx), .busy(busy), .seg_n(seg_n), .an_n(an_n)
  );

  function automatic logic [6:0] seg_exp(input logic [2:0] v);
    logic [6:0] p;
    case (v)
      3'd0: p = 7'h3F; 3'd1: p = 7'h06; 3'd2: p = 7'h5B; 3'd3: p = 7'h4F;
      3'd4: p = 7'h66; 3'd5: p = 7'h6D; 3'd6: p = 7'h7D; default: p = 7'h07;
    endcase
    return ~p;
  endfunction

  function automatic logic [7:0] asc(input logic [2:0] v);
    return 8'h30 + {5'd0, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // waits for a start bit, then checks every cycle of the frame
  task automatic frame_check(input logic [7:0] c, input string req);
    int n = 0;
    int errs = 0;
    logic [9:0] fr;
    logic [7:0] rx = 8'h00;
    fr = {1'b1, c, 1'b0};
    while (tx !== 1'b0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) begin
      chk(1'b0, req, "no start bit", 1, 0);
      return;
    end
    for (int k = 0; k < 10 * DIV; k++) begin
      if (tx !== fr[k / DIV]) errs++;
      if (busy !== 1'b1) errs++;
      if ((k % DIV) == DIV / 2 && k >= DIV && k < 9 * DIV)
        rx[k / DIV - 1] = tx;
      @(negedge clk);
    end
    chk(errs == 0 && rx == c, req, "frame bits/timing", int'(rx), int'(c));
    chk(busy === 1'b0 && tx === 1'b1, "R8", "end of frame busy,tx",
        int'({busy, tx}), 1);
  endtask

  task automatic idle_for(input int cyc, input string req);
    int errs = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (tx !== 1'b1 || busy !== 1'b0) errs++;
    end
    chk(errs == 0, req, "unexpected activity cycles", errs, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned r;
    r = $urandom(32'd20240611);

    // R1: reset values
    repeat (3) @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R1", "tx,busy in reset",
        int'({tx, busy}), 2);
    chk(seg_n === 7'h7F, "R1", "seg_n in reset", int'(seg_n), 'h7F);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: one anode low
    chk(an_n === 4'b1110, "R5", "an_n", int'(an_n), 'hE);

    // R4: every digit
    for (int v = 0; v < 8; v++) begin
      sw = 3'(v);
      @(negedge clk);
      chk(seg_n === seg_exp(3'(v)), "R4", "seg_n", int'(seg_n),
          int'(seg_exp(3'(v))));
    end

    // R6: latency from button to start bit
    sw = 3'd3;
    @(negedge clk);
    btn = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R6", "tx three edges after press", int'(tx), 1);
    @(negedge clk);
    chk(tx === 1'b0, "R6", "tx four edges after press", int'(tx), 0);
    frame_check(asc(3'd3), "R2");
    btn = 1'b0;
    idle_for(2 * DIV, "R7");

    // R7: long hold gives one frame only
    sw = 3'd5;
    @(negedge clk);
    btn = 1'b1;
    fork
      begin repeat (30 * DIV) @(negedge clk); btn = 1'b0; end
      begin frame_check(asc(3'd5), "R7"); idle_for(15 * DIV, "R7"); end
    join
    idle_for(3 * DIV, "R7");

    // R9: a second press during a frame is dropped
    sw = 3'd6;
    @(negedge clk);
    btn = 1'b1;
    fork
      begin
        repeat (6) @(negedge clk);
        btn = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        btn = 1'b1;
        sw = 3'd2;
        repeat (8) @(negedge clk);
        btn = 1'b0;
      end
      frame_check(asc(3'd6), "R9");
    join
    idle_for(4 * DIV, "R9");

    // R3: random values, random holds, switches move mid-frame
    for (int it = 0; it < 10; it++) begin
      logic [2:0] v, nv;
      int hold;
      v    = 3'($urandom);
      nv   = 3'($urandom);
      hold = 5 + int'($urandom % 40);
      sw = v;
      @(negedge clk);
      btn = 1'b1;
      fork
        begin repeat (hold) @(negedge clk); btn = 1'b0; sw = nv; end
        frame_check(asc(v), "R3");
      join
      @(negedge clk);
      chk(seg_n === seg_exp(nv), "R4", "seg_n after frame", int'(seg_n),
          int'(seg_exp(nv)));
      repeat (int'($urandom % 4)) @(negedge clk);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule